// File: doc/BRIEF.md
# Call, Jump and Trap Next-PC Unit

This unit decides where a 16-bit processor goes next when it executes a subroutine call, a register jump (return is the same jump through R7), or a system-call trap. It reads the instruction register, the already-incremented PC and one register-file read port. It then produces a PC load with its target, and a write of the return address into the fixed link register R7.

Calls and jumps resolve in the cycle the instruction is presented. A call has two forms. Bit 11 of the instruction set to 1 gives a PC-relative target, `pc_inc` plus the sign-extended IR[10:0]. Bit 11 at 0 gives a target taken from the register named by IR[8:6].

A trap takes the 8-bit vector in IR[7:0] and zero-extends it into an address in the service table that occupies words 0x0000 to 0x00FF. The unit issues that address as a one-cycle read request and holds the processor stalled until the read data returns. The returned word becomes the new PC, and the link register receives the return address that was captured when the trap was accepted.

Top module: `ctl_xfer_unit`

## Requirements
- R1: Opcode 0100 (IR[15:12]) with IR[11]=1 and `instr_valid` high in the idle state asserts `pc_load` in that same cycle, with `pc_next` = `pc_inc` + sign-extended IR[10:0].
- R2: Opcode 0100 with IR[11]=0 asserts `pc_load` in that same cycle with `pc_next` = `base_data`. `base_sel` always equals IR[8:6].
- R3: Every accepted call asserts `link_we` together with `pc_load`, with `link_data` = `pc_inc` of that cycle.
- R4: Opcode 1100 loads `pc_next` = `base_data` in that same cycle without asserting `link_we`. Return is this opcode with IR[8:6]=7.
- R5: A register-mode call whose base is R7 takes its target from the `base_data` value present in the cycle the link write is issued, so the target is the old R7 and not the link value.
- R6: Opcode 1111 accepted in idle causes `mem_req` to be high for exactly the next cycle, with `mem_addr` = {8'h00, IR[7:0]}.
- R7: After the request, the first cycle with `mem_rvalid` high asserts `pc_load` with `pc_next` = `mem_rdata`, and `link_we` with `link_data` = the `pc_inc` sampled when the trap was accepted.
- R8: `stall` is high from the trap acceptance cycle up to, but not including, the completion cycle. While the unit is busy, `instr_valid` is ignored.
- R9: Any other opcode, or `instr_valid` low, produces no `pc_load`, `link_we`, `mem_req` or `stall`.
- R10: After reset the unit is idle, with `pc_load`, `link_we`, `mem_req` and `stall` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | IR holds an instruction to execute this cycle |
| ir | input | 16 | Instruction register |
| pc_inc | input | 16 | Address of the following instruction |
| base_sel | output | 3 | Register-file read index (IR[8:6]) |
| base_data | input | 16 | Register-file read data for `base_sel` |
| pc_load | output | 1 | Load `pc_next` into the PC |
| pc_next | output | 16 | New PC value |
| link_we | output | 1 | Write `link_data` into R7 |
| link_data | output | 16 | Return address |
| mem_req | output | 1 | Service-table read request |
| mem_addr | output | 16 | Service-table address |
| mem_rvalid | input | 1 | Table read data valid |
| mem_rdata | input | 16 | Table read data |
| stall | output | 1 | Hold fetch while a trap is in progress |

## Verification
Two events can coincide. A new call or jump can appear on `instr_valid` in the same cycle a trap is still waiting for its table word. Separately, a register-mode call through R7 writes the link value in the same cycle it reads R7 as its target. The bench drives a valid call during the request and wait cycles of a trap and changes `pc_inc` there. The scoreboard then requires that no unexpected PC load appears and that the trap completes with its own target and its originally captured return address. For the R7 case, `base_data` carries a known old value, and the PC target must equal that value, not `pc_inc`.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
    localparam int WORD_W = 16;
    localparam int VEC_W  = 8;

    localparam logic [3:0] OPC_CALL = 4'b0100;
    localparam logic [3:0] OPC_JUMP = 4'b1100;
    localparam logic [3:0] OPC_TRAP = 4'b1111;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_WAIT  = 2'd2
    } seq_e;

    typedef struct packed {
        seq_e              st;
        logic [WORD_W-1:0] vec_addr;
        logic [WORD_W-1:0] ret_pc;
    } seq_t;
endpackage

// File: rtl/xfer_decode.sv
module xfer_decode
    import xfer_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         valid,
    input  logic [W-1:0] ir,
    output logic         is_call,
    output logic         is_jump,
    output logic         is_trap,
    output logic         call_rel
);
    logic [3:0] opc;

    always_comb begin
        opc      = ir[W-1 -: 4];
        is_call  = valid && (opc == OPC_CALL);
        is_jump  = valid && (opc == OPC_JUMP);
        is_trap  = valid && (opc == OPC_TRAP);
        call_rel = is_call && ir[11];
    end
endmodule

// File: rtl/xfer_target.sv
module xfer_target
    import xfer_pkg::*;
#(
    parameter int W    = WORD_W,
    parameter int OFFW = 11
) (
    input  logic [W-1:0] pc_inc,
    input  logic [W-1:0] ir,
    input  logic [W-1:0] base_data,
    input  logic         rel,
    output logic [W-1:0] target
);
    logic [W-1:0] offs;

    always_comb begin
        offs   = {{(W-OFFW){ir[OFFW-1]}}, ir[OFFW-1:0]};
        target = rel ? (pc_inc + offs) : base_data;
    end
endmodule

// File: rtl/ctl_xfer_unit.sv
module ctl_xfer_unit
    import xfer_pkg::*;
#(
    parameter int W    = WORD_W,
    parameter int VECW = VEC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         instr_valid,
    input  logic [W-1:0] ir,
    input  logic [W-1:0] pc_inc,
    output logic [2:0]   base_sel,
    input  logic [W-1:0] base_data,
    output logic         pc_load,
    output logic [W-1:0] pc_next,
    output logic         link_we,
    output logic [W-1:0] link_data,
    output logic         mem_req,
    output logic [W-1:0] mem_addr,
    input  logic         mem_rvalid,
    input  logic [W-1:0] mem_rdata,
    output logic         stall
);
    localparam int PADW = W - VECW;

    seq_t s_q, s_d;
    logic is_call, is_jump, is_trap, call_rel;
    logic [W-1:0] target;
    logic accept;

    assign accept   = (s_q.st == SEQ_IDLE) && instr_valid;
    assign base_sel = ir[8:6];

    xfer_decode #(.W(W)) u_dec (
        .valid    (accept),
        .ir       (ir),
        .is_call  (is_call),
        .is_jump  (is_jump),
        .is_trap  (is_trap),
        .call_rel (call_rel)
    );

    xfer_target #(.W(W), .OFFW(11)) u_tgt (
        .pc_inc    (pc_inc),
        .ir        (ir),
        .base_data (base_data),
        .rel       (call_rel),
        .target    (target)
    );

    always_comb begin
        s_d       = s_q;
        pc_load   = 1'b0;
        pc_next   = '0;
        link_we   = 1'b0;
        link_data = '0;
        mem_req   = 1'b0;
        mem_addr  = '0;
        stall     = 1'b0;
        case (s_q.st)
            SEQ_IDLE: begin
                if (is_call) begin
                    pc_load   = 1'b1;
                    pc_next   = target;
                    link_we   = 1'b1;
                    link_data = pc_inc;
                end else if (is_jump) begin
                    pc_load = 1'b1;
                    pc_next = target;
                end else if (is_trap) begin
                    stall      = 1'b1;
                    s_d.st     = SEQ_ISSUE;
                    s_d.vec_addr = {{PADW{1'b0}}, ir[VECW-1:0]};
                    s_d.ret_pc = pc_inc;
                end
            end
            SEQ_ISSUE: begin
                stall    = 1'b1;
                mem_req  = 1'b1;
                mem_addr = s_q.vec_addr;
                s_d.st   = SEQ_WAIT;
            end
            SEQ_WAIT: begin
                if (mem_rvalid) begin
                    pc_load   = 1'b1;
                    pc_next   = mem_rdata;
                    link_we   = 1'b1;
                    link_data = s_q.ret_pc;
                    s_d.st    = SEQ_IDLE;
                end else begin
                    stall = 1'b1;
                end
            end
            default: s_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: SEQ_IDLE, vec_addr: '0, ret_pc: '0};
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/ctl_xfer_unit_chk.sv
module ctl_xfer_unit_chk #(
    parameter int W    = 16,
    parameter int VECW = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         pc_load,
    input logic         link_we,
    input logic         mem_req,
    input logic [W-1:0] mem_addr,
    input logic         stall
);
    AST_LINK_WITH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> pc_load); // R3
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req); // R6
    AST_REQ_TABLE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[W-1:VECW] == '0)); // R6
    AST_REQ_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (stall && !pc_load)); // R8
    AST_REQ_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> $past(stall)); // R8
    AST_LOAD_ENDS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> !stall); // R7
endmodule

bind ctl_xfer_unit ctl_xfer_unit_chk #(.W(W), .VECW(VECW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pc_load  (pc_load),
    .link_we  (link_we),
    .mem_req  (mem_req),
    .mem_addr (mem_addr),
    .stall    (stall)
);

// File: tb/sim_ctl_xfer_unit.sv
module sim_ctl_xfer_unit;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 5000;

    typedef struct {
        logic [15:0] pc;
        logic        lk;
        logic [15:0] ld;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic instr_valid = 1'b0;
    logic [15:0] ir = '0, pc_inc = '0, base_data = '0, mem_rdata = '0;
    logic mem_rvalid = 1'b0;
    logic [2:0] base_sel;
    logic pc_load, link_we, mem_req, stall;
    logic [15:0] pc_next, link_data, mem_addr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ctl_xfer_unit u0 (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .ir(ir),
        .pc_inc(pc_inc), .base_sel(base_sel), .base_data(base_data),
        .pc_load(pc_load), .pc_next(pc_next), .link_we(link_we),
        .link_data(link_data), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .stall(stall)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compares every PC load against the scoreboard queue
    always @(negedge clk) begin
        #2;
        if (rst_n && pc_load) begin
            checks++;
            if (q.size() == 0) begin
                errors++;
                $display("FAIL R8/R9 unexpected load actual=%h expected=none", pc_next);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (pc_next !== e.pc || link_we !== e.lk || (e.lk && link_data !== e.ld)) begin
                    errors++;
                    $display("FAIL %s actual=%h/%b/%h expected=%h/%b/%h",
                             e.tag, pc_next, link_we, link_data, e.pc, e.lk, e.ld);
                end
            end
        end
    end

    // driver: presents one instruction for one cycle and queues the expected result
    task automatic drive(input logic [15:0] i, input logic [15:0] p, input logic [15:0] b,
                         input logic ld, input logic [15:0] epc, input logic elk, input string tag);
        @(negedge clk);
        instr_valid = 1'b1; ir = i; pc_inc = p; base_data = b;
        if (ld) q.push_back('{epc, elk, p, tag});
        #1;
        check({tag, " base_sel"}, {29'd0, base_sel}, {29'd0, i[8:6]});
        if (!ld) begin
            check({tag, " quiet"}, {29'd0, link_we, mem_req, stall}, 32'd0);
        end
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    task automatic trap(input logic [7:0] v, input logic [15:0] p, input logic [15:0] svc,
                        input int waits);
        @(negedge clk);
        instr_valid = 1'b1; ir = 16'hF000 | {8'h00, v}; pc_inc = p;
        #1;
        check("R8 stall at accept", {31'd0, stall}, 32'd1);
        check("R6 no req at accept", {31'd0, mem_req}, 32'd0);
        @(negedge clk);
        // a call presented while busy must be ignored (R8)
        ir = 16'h4805; pc_inc = 16'hBEEF;
        #1;
        check("R6 req", {31'd0, mem_req}, 32'd1);
        check("R6 addr", {16'd0, mem_addr}, {24'd0, v});
        check("R8 stall in issue", {31'd0, stall}, 32'd1);
        for (int k = 0; k < waits; k++) begin
            @(negedge clk);
            #1;
            check("R6 single req", {31'd0, mem_req}, 32'd0);
            check("R8 stall in wait", {31'd0, stall}, 32'd1);
        end
        @(negedge clk);
        instr_valid = 1'b0;
        mem_rvalid = 1'b1; mem_rdata = svc;
        q.push_back('{svc, 1'b1, p, "R7 trap completion"});
        #1;
        check("R8 stall drops", {31'd0, stall}, 32'd0);
        @(negedge clk);
        mem_rvalid = 1'b0;
        #1;
        check("R8 idle after trap", {31'd0, stall}, 32'd0);
    endtask

    initial begin
        while (cycles < MAX_CYCLES) begin
            @(posedge clk);
            cycles++;
        end
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected<%0d", cycles, MAX_CYCLES);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R10 reset outputs", {28'd0, pc_load, link_we, mem_req, stall}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R10 idle after reset", {28'd0, pc_load, link_we, mem_req, stall}, 32'd0);

        drive(16'h4800 | 16'h0010, 16'h3001, 16'h0000, 1, 16'h3011, 1, "R1/R3 rel fwd");
        drive(16'h4800 | 16'h0400, 16'h3500, 16'h0000, 1, 16'h3100, 1, "R1/R3 rel back");
        drive(16'h4800 | 16'h07FF, 16'h0000, 16'h0000, 1, 16'hFFFF, 1, "R1 rel wrap");
        drive(16'h4000 | (16'd3 << 6), 16'h3020, 16'h5A5A, 1, 16'h5A5A, 1, "R2/R3 reg mode");
        drive(16'h4000 | (16'd7 << 6), 16'h3040, 16'h1234, 1, 16'h1234, 1, "R5 R7 base");
        drive(16'hC000 | (16'd2 << 6), 16'h3050, 16'h4444, 1, 16'h4444, 0, "R4 jump");
        drive(16'hC000 | (16'd7 << 6), 16'h0431, 16'h3003, 1, 16'h3003, 0, "R4 return");
        drive(16'h1283, 16'h3060, 16'h7777, 0, 16'h0, 0, "R9 other opcode");

        @(negedge clk);
        ir = 16'h4805; pc_inc = 16'h3070; instr_valid = 1'b0;
        #1;
        check("R9 invalid call", {28'd0, pc_load, link_we, mem_req, stall}, 32'd0);

        trap(8'h21, 16'h3008, 16'h0430, 0);
        trap(8'h25, 16'h3100, 16'hFD70, 3);
        trap(8'h20, 16'h3200, 16'h0400, 1);
        drive(16'h4800 | 16'h0002, 16'h3300, 16'h0000, 1, 16'h3302, 1, "R1 after trap");

        repeat (3) @(negedge clk);
        check("R7 scoreboard drained", q.size(), 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule